// File: doc/BRIEF.md
# System Control Register Block

This block is a small bank of 32-bit control and identification registers reached over a plain word-wide read/write bus. It gives software a way to drive and read general-purpose pins, run two independent up-counting interval timers, leave a value in a scratch word that can be frozen for debugging, and learn fixed facts about the chip: its clock rate, its capability flags and a system identifier.

A few registers do more than store data. A write to the identifier word asks the chip for a reset. A particular command code written to the configuration command word asks for a shutdown. A write of any value to the lock word sets a sticky flag that protects the scratch word. Both requests leave the block as one-cycle pulses for the chip's power and reset logic to act on.

The bus is byte-addressed. The register index is the address shifted right by two, and reads are combinational. Only aligned accesses that carry all four byte enables change state. Each timer is a separate instance of one timer module.

Top module: `sysctl_ctrl`

## Requirements
- R1: The register index is bus_addr[6:2]. Any address at or above byte 128, and any index with no register (3, 7, 11 to 15, 17 to 19, 22 to 28), reads as 0 and ignores writes.
- R2: A write changes state only when bus_be is 4'hF and bus_addr[1:0] is 0. Any other write has no effect and raises no request. A misaligned address reads as 0.
- R3: After reset, index 29 reads 80000000, index 30 reads 0, index 31 reads 0x10014D31, index 0 reads the strap value 1, and index 16 reads 1 (ready flag in bit 0). Every other index reads 0.
- R4: Index 0 shows the value gpio_pins held at the previous clock edge, zero-extended. Writes to indices 0, 29 and 30 are ignored.
- R5: Index 1 (pin output) and index 2 (pin interrupt enable) store the low GPIO_W bits of a write. They read back zero-extended and drive gpio_out and gpio_irq_en.
- R6: A write to index 31 raises reset_req for exactly the next cycle, and index 31 keeps its identifier value.
- R7: A write to index 16 whose low 16 bits are 0x000E raises shutdown_req for exactly the next cycle. Other values raise nothing. Index 16 always reads 1.
- R8: A write of any data to index 21 sets it to 1 until reset. Index 20 (scratch) stores writes while index 21 is 0 and ignores them once it is 1.
- R9: Timer k (k = 0, 1) has control at index 4+4k, where bit 0 is enable and bit 1 is auto-restart, compare at 5+4k and counter at 6+4k. All three read back, and while enabled the counter rises by 1 each cycle.
- R10: When an enabled timer's counter equals its compare value, the counter returns to 0 and timer_irq[k] is high for the following cycle. Without auto-restart, control bit 0 clears at that same edge.
- R11: With auto-restart, the timer stays enabled and timer_irq[k] pulses every compare+1 cycles.
- R12: A bus write to any register of a timer takes priority over that timer's count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| gpio_pins | input | GPIO_W | Pin input levels |
| gpio_out | output | GPIO_W | Pin output register |
| gpio_irq_en | output | GPIO_W | Pin interrupt enable register |
| timer_irq | output | 2 | One-cycle timer match pulses |
| reset_req | output | 1 | One-cycle reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The bench uses the defaults ADDR_W = 8, GPIO_W = 8 and CNT_W = 32. With an 8-bit address the bench can reach bytes 128 to 255, and there the aliasing of index 33 onto index 1 would show if the range check were missing. With eight pins, random 32-bit writes show that the upper bits are dropped. The timers are run with small compare values, so the bench can count each match cycle and the auto-restart period exactly. A large compare value lets it test counting and write priority without a match getting in the way.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BE_W      = DATA_W / 8;
    localparam int unsigned MAP_IDX_W = 5;
    localparam int unsigned N_TMR     = 2;
    localparam int unsigned MAP_BYTES = (1 << MAP_IDX_W) * BE_W;

    localparam logic [MAP_IDX_W-1:0] OFS_GPIN   = 5'd0;
    localparam logic [MAP_IDX_W-1:0] OFS_GPOUT  = 5'd1;
    localparam logic [MAP_IDX_W-1:0] OFS_GPIEN  = 5'd2;
    localparam logic [MAP_IDX_W-1:0] OFS_T0_CTL = 5'd4;
    localparam logic [MAP_IDX_W-1:0] OFS_T0_CMP = 5'd5;
    localparam logic [MAP_IDX_W-1:0] OFS_T0_CNT = 5'd6;
    localparam logic [MAP_IDX_W-1:0] OFS_T1_CTL = 5'd8;
    localparam logic [MAP_IDX_W-1:0] OFS_T1_CMP = 5'd9;
    localparam logic [MAP_IDX_W-1:0] OFS_T1_CNT = 5'd10;
    localparam logic [MAP_IDX_W-1:0] OFS_CFG    = 5'd16;
    localparam logic [MAP_IDX_W-1:0] OFS_SCR    = 5'd20;
    localparam logic [MAP_IDX_W-1:0] OFS_LOCK   = 5'd21;
    localparam logic [MAP_IDX_W-1:0] OFS_FREQ   = 5'd29;
    localparam logic [MAP_IDX_W-1:0] OFS_CAPS   = 5'd30;
    localparam logic [MAP_IDX_W-1:0] OFS_SYSID  = 5'd31;

    localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;

    typedef enum logic [3:0] {
        RG_NONE, RG_GPIN, RG_GPOUT, RG_GPIEN,
        RG_TCTL, RG_TCMP, RG_TCNT,
        RG_CFG, RG_SCR, RG_LOCK,
        RG_FREQ, RG_CAPS, RG_SYSID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      tsel;
    } reg_sel_t;

    // bit 0 enable, bit 1 auto-restart
    typedef struct packed {
        logic auto_rst;
        logic en;
    } tmr_ctl_t;

    function automatic reg_sel_t decode_word(input logic [MAP_IDX_W-1:0] w);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.tsel = 1'b0;
        case (w)
            OFS_GPIN:   s.kind = RG_GPIN;
            OFS_GPOUT:  s.kind = RG_GPOUT;
            OFS_GPIEN:  s.kind = RG_GPIEN;
            OFS_T0_CTL: s.kind = RG_TCTL;
            OFS_T0_CMP: s.kind = RG_TCMP;
            OFS_T0_CNT: s.kind = RG_TCNT;
            OFS_T1_CTL: begin s.kind = RG_TCTL; s.tsel = 1'b1; end
            OFS_T1_CMP: begin s.kind = RG_TCMP; s.tsel = 1'b1; end
            OFS_T1_CNT: begin s.kind = RG_TCNT; s.tsel = 1'b1; end
            OFS_CFG:    s.kind = RG_CFG;
            OFS_SCR:    s.kind = RG_SCR;
            OFS_LOCK:   s.kind = RG_LOCK;
            OFS_FREQ:   s.kind = RG_FREQ;
            OFS_CAPS:   s.kind = RG_CAPS;
            OFS_SYSID:  s.kind = RG_SYSID;
            default:    s.kind = RG_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    output reg_sel_t          sel,
    output logic              wr_fire
);
    localparam int unsigned LSB_W  = $clog2(BE_W);
    localparam int unsigned TOP_LO = LSB_W + MAP_IDX_W;

    logic in_range;
    logic aligned;

    generate
        if (ADDR_W > TOP_LO) begin : g_hi
            assign in_range = ~|addr[ADDR_W-1:TOP_LO];
        end else begin : g_nohi
            assign in_range = 1'b1;
        end
    endgenerate

    assign aligned = ~|addr[LSB_W-1:0];

    always_comb begin
        sel = decode_word(addr[TOP_LO-1:LSB_W]);
        if (!(in_range && aligned)) begin
            sel.kind = RG_NONE;
            sel.tsel = 1'b0;
        end
    end

    assign wr_fire = wr && (&be);

endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic             wr_cmp,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    output tmr_ctl_t         ctl_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq
);
    logic bus_touch;
    logic hit;

    assign bus_touch = wr_ctl || wr_cmp || wr_cnt;
    assign hit       = ctl_q.en && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_q <= '0;
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (bus_touch) begin
                if (wr_ctl) begin
                    ctl_q.en       <= wdata[0];
                    ctl_q.auto_rst <= wdata[1];
                end
                if (wr_cmp) cmp_q <= wdata;
                if (wr_cnt) cnt_q <= wdata;
            end else if (hit) begin
                cnt_q <= '0;
                irq   <= 1'b1;
                if (!ctl_q.auto_rst) ctl_q.en <= 1'b0;
            end else if (ctl_q.en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
    import sysctl_pkg::*;
#(
    parameter int unsigned      ADDR_W = 8,
    parameter int unsigned      GPIO_W = 8,
    parameter int unsigned      CNT_W  = 32,
    parameter logic [31:0]      CLK_HZ = 32'd80_000_000,
    parameter logic [31:0]      CAPS   = 32'h0000_0000,
    parameter logic [31:0]      SYS_ID = 32'h1001_4D31,
    parameter logic [GPIO_W-1:0] STRAP = GPIO_W'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] gpio_pins,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_irq_en,
    output logic [N_TMR-1:0]  timer_irq,
    output logic              reset_req,
    output logic              shutdown_req
);
    reg_sel_t          sel;
    logic              wr_fire;
    logic [GPIO_W-1:0] gpin_q;
    logic [DATA_W-1:0] scratch_q;
    logic              lock_q;

    tmr_ctl_t          t_ctl [N_TMR];
    logic [CNT_W-1:0]  t_cmp [N_TMR];
    logic [CNT_W-1:0]  t_cnt [N_TMR];

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .be      (bus_be),
        .sel     (sel),
        .wr_fire (wr_fire)
    );

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            logic mine;
            assign mine = wr_fire && (sel.tsel == 1'(i));
            sysctl_timer #(.CNT_W(CNT_W)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .wr_ctl (mine && sel.kind == RG_TCTL),
                .wr_cmp (mine && sel.kind == RG_TCMP),
                .wr_cnt (mine && sel.kind == RG_TCNT),
                .wdata  (bus_wdata[CNT_W-1:0]),
                .ctl_q  (t_ctl[i]),
                .cmp_q  (t_cmp[i]),
                .cnt_q  (t_cnt[i]),
                .irq    (timer_irq[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gpin_q       <= STRAP;
            gpio_out     <= '0;
            gpio_irq_en  <= '0;
            scratch_q    <= '0;
            lock_q       <= 1'b0;
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            gpin_q       <= gpio_pins;
            reset_req    <= wr_fire && (sel.kind == RG_SYSID);
            shutdown_req <= wr_fire && (sel.kind == RG_CFG)
                            && (bus_wdata[15:0] == CMD_SHUTDOWN);
            if (wr_fire) begin
                case (sel.kind)
                    RG_GPOUT: gpio_out    <= bus_wdata[GPIO_W-1:0];
                    RG_GPIEN: gpio_irq_en <= bus_wdata[GPIO_W-1:0];
                    RG_SCR:   if (!lock_q) scratch_q <= bus_wdata;
                    RG_LOCK:  lock_q <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            RG_GPIN:  bus_rdata = DATA_W'(gpin_q);
            RG_GPOUT: bus_rdata = DATA_W'(gpio_out);
            RG_GPIEN: bus_rdata = DATA_W'(gpio_irq_en);
            RG_TCTL:  bus_rdata = DATA_W'(t_ctl[sel.tsel]);
            RG_TCMP:  bus_rdata = DATA_W'(t_cmp[sel.tsel]);
            RG_TCNT:  bus_rdata = DATA_W'(t_cnt[sel.tsel]);
            RG_CFG:   bus_rdata = DATA_W'(1);
            RG_SCR:   bus_rdata = scratch_q;
            RG_LOCK:  bus_rdata = DATA_W'(lock_q);
            RG_FREQ:  bus_rdata = CLK_HZ;
            RG_CAPS:  bus_rdata = CAPS;
            RG_SYSID: bus_rdata = SYS_ID;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_ctrl_chk.sv
module sysctl_ctrl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned GPIO_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [GPIO_W-1:0] gpio_out,
    input logic              reset_req,
    input logic              shutdown_req,
    input logic              lock_q
);
    logic full_wr;
    assign full_wr = bus_wr && (bus_be == 4'hF);

    // R6
    reset_cause_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(full_wr && bus_addr == ADDR_W'(31 * 4)));

    // R7
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(full_wr && bus_addr == ADDR_W'(16 * 4)
                               && bus_wdata[15:0] == 16'h000E));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lock_q) |-> lock_q);

    // R5
    gpio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(full_wr && bus_addr == ADDR_W'(1 * 4)) |-> $stable(gpio_out));

    // R2
    partial_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_be != 4'hF) |=> (!reset_req && !shutdown_req));

    generate
        if (ADDR_W > 7) begin : g_far
            // R1
            far_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (bus_addr >= ADDR_W'(128)) |-> (bus_rdata == 32'd0));
        end
    endgenerate

endmodule

bind sysctl_ctrl sysctl_ctrl_chk #(.ADDR_W(ADDR_W), .GPIO_W(GPIO_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .gpio_out     (gpio_out),
    .reset_req    (reset_req),
    .shutdown_req (shutdown_req),
    .lock_q       (lock_q)
);

// File: tb/sysctl_ctrl_test.sv
module sysctl_ctrl_test;
    localparam int ADDR_W = 8;
    localparam int GPIO_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_be = 4'h0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [GPIO_W-1:0] gpio_pins = '0;
    logic [GPIO_W-1:0] gpio_out;
    logic [GPIO_W-1:0] gpio_irq_en;
    logic [1:0]        timer_irq;
    logic              reset_req;
    logic              shutdown_req;

    int n_chk = 0;
    int n_err = 0;
    logic saw_rst, saw_sd;
    logic [31:0] v;
    logic [31:0] m_out, m_ien, m_scr;

    sysctl_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_pins(gpio_pins), .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en),
        .timer_irq(timer_irq), .reset_req(reset_req), .shutdown_req(shutdown_req)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_reset(input int idx);
        case (idx)
            0:  return 32'd1;
            16: return 32'd1;
            29: return 32'd80_000_000;
            31: return 32'h1001_4D31;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input int idx, input logic [31:0] d,
                      input logic [3:0] be = 4'hF, input int off = 0);
        bus_addr  = ADDR_W'(idx * 4 + off);
        bus_wdata = d;
        bus_be    = be;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr  = 1'b0;
        bus_be  = 4'h0;
        saw_rst = reset_req;
        saw_sd  = shutdown_req;
    endtask

    task automatic rd(input int idx, output logic [31:0] d, input int off = 0);
        bus_addr = ADDR_W'(idx * 4 + off);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int k, input int lows, input string tag);
        for (int i = 0; i < lows; i++) begin
            @(negedge clk);
            chk(tag, 32'(timer_irq[k]), 32'd0);
        end
        @(negedge clk);
        chk(tag, 32'(timer_irq[k]), 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3 reset contents
        for (int i = 0; i < 32; i++) begin
            rd(i, v);
            chk($sformatf("R3 idx %0d", i), v, exp_reset(i));
        end
        chk("R3 requests idle", {30'd0, reset_req, shutdown_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4 pin sampling and read-only words
        gpio_pins = 8'hA5;
        @(negedge clk);
        rd(0, v); chk("R4 pins sampled", v, 32'h0000_00A5);
        wr(0, 32'hFFFF_FFFF);  rd(0, v);  chk("R4 idx0 write ignored", v, 32'h0000_00A5);
        wr(29, 32'h1234_5678); rd(29, v); chk("R4 freq write ignored", v, 32'd80_000_000);
        wr(30, 32'hFFFF_FFFF); rd(30, v); chk("R4 caps write ignored", v, 32'd0);

        // R5 / R2 / R8 random register traffic
        m_out = 0; m_ien = 0; m_scr = 0;
        for (int it = 0; it < 40; it++) begin
            int sel, idx;
            logic [31:0] d;
            logic [3:0] be;
            sel = $urandom % 3;
            idx = (sel == 0) ? 1 : (sel == 1) ? 2 : 20;
            d   = $urandom;
            be  = (($urandom % 4) == 0) ? 4'($urandom % 15) : 4'hF;
            wr(idx, d, be);
            if (be == 4'hF) begin
                if (idx == 1) m_out = {24'd0, d[7:0]};
                if (idx == 2) m_ien = {24'd0, d[7:0]};
                if (idx == 20) m_scr = d;
            end
            rd(idx, v);
            chk((be != 4'hF) ? "R2 partial write" : (idx == 20) ? "R8 scratch" : "R5 gpio reg",
                v, (idx == 1) ? m_out : (idx == 2) ? m_ien : m_scr);
            chk("R5 gpio_out port", 32'(gpio_out), m_out);
            chk("R5 gpio_irq_en port", 32'(gpio_irq_en), m_ien);
        end
        // R2 misaligned full-enable write
        wr(1, 32'h0000_003C, 4'hF, 2);
        chk("R2 misaligned write", 32'(gpio_out), m_out);
        rd(1, v, 2); chk("R2 misaligned read", v, 32'd0);

        // R1 unmapped and out-of-range
        wr(33, 32'h0000_00FF); chk("R1 idx33 no alias", 32'(gpio_out), m_out);
        rd(33, v); chk("R1 idx33 reads 0", v, 32'd0);
        wr(3, 32'hDEAD_BEEF);  rd(3, v);  chk("R1 idx3 reads 0", v, 32'd0);
        wr(17, 32'hDEAD_BEEF); rd(17, v); chk("R1 idx17 reads 0", v, 32'd0);
        rd(25, v); chk("R1 idx25 reads 0", v, 32'd0);

        // R6 reset request
        wr(31, 32'h0);
        chk("R6 reset pulse", 32'(saw_rst), 32'd1);
        @(negedge clk);
        chk("R6 pulse one cycle", 32'(reset_req), 32'd0);
        rd(31, v); chk("R6 id kept", v, 32'h1001_4D31);
        wr(31, 32'h0, 4'h7);
        chk("R2 partial id write no reset", 32'(saw_rst), 32'd0);

        // R7 shutdown request
        wr(16, 32'hABCD_000E);
        chk("R7 shutdown pulse", 32'(saw_sd), 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", 32'(shutdown_req), 32'd0);
        wr(16, 32'h0000_000F);
        chk("R7 other code no pulse", 32'(saw_sd), 32'd0);
        rd(16, v); chk("R7 ready readback", v, 32'd1);

        // R8 lock
        wr(20, 32'h0000_1234);
        rd(20, v); chk("R8 scratch unlocked", v, 32'h0000_1234);
        wr(21, 32'h0);
        rd(21, v); chk("R8 lock set by zero write", v, 32'd1);
        wr(20, 32'hCAFE_F00D);
        rd(20, v); chk("R8 scratch frozen", v, 32'h0000_1234);
        wr(21, 32'h0);
        rd(21, v); chk("R8 lock stays", v, 32'd1);

        // R10 one-shot timer 0, compare 3
        wr(5, 32'd3);
        wr(4, 32'd1);
        wait_irq(0, 3, "R10 one-shot match");
        @(negedge clk);
        chk("R10 irq one cycle", 32'(timer_irq[0]), 32'd0);
        rd(4, v); chk("R10 enable cleared", v, 32'd0);
        rd(6, v); chk("R10 counter wrapped", v, 32'd0);
        rd(5, v); chk("R9 compare readback", v, 32'd3);

        // R9 counting, R12 write priority on timer 1
        wr(9, 32'd1000);
        wr(8, 32'd1);
        repeat (20) @(negedge clk);
        wr(8, 32'd0);
        rd(10, v); chk("R9 counted 20 cycles", v, 32'd20);
        wr(8, 32'd1);
        wr(10, 32'd500);
        wr(8, 32'd0);
        rd(10, v); chk("R12 bus write wins", v, 32'd500);
        rd(9, v);  chk("R9 compare1 readback", v, 32'd1000);

        // R11 auto-restart timer 1, compare 2
        wr(9, 32'd2);
        wr(10, 32'd0);
        wr(8, 32'd3);
        wait_irq(1, 2, "R11 first pulse");
        rd(8, v); chk("R11 stays enabled", v, 32'd3);
        wait_irq(1, 2, "R11 second pulse");
        wait_irq(1, 2, "R11 third pulse");
        chk("R11 timer0 quiet", 32'(timer_irq[0]), 32'd0);
        wr(8, 32'd0);
        rd(8, v); chk("R9 control readback", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule